// File: doc/BRIEF.md
# ADC Channel-List Sampling Sequencer

This block is the control engine that sits in front of a successive-approximation converter. Software programs a list of up to eight channel slots, a last-slot index and a settle delay, then strobes start. The engine asks the converter for one conversion per slot through a request/done handshake. It waits the settle delay between conversions and stores each 12-bit result, tagged with the channel it came from, in a 32-entry result FIFO. Software drains the FIFO by reading a pop word.

A single pass runs over slots 0 up to the last index and then returns to idle. Continuous mode wraps back to slot 0 until software asks it to stop. A stop request never cuts a running conversion short: the result is stored first and the engine then goes idle. The busy flag is raised on the same clock edge that accepts start, so a status poll issued right after the start write cannot see a false idle.

The register interface has a write strobe, and a read strobe whose data returns one cycle later. The converter side is a request held high until a one-cycle done pulse that carries the code.

Top module: `adc_seq_engine`

## Requirements
- R1: After reset, the status word (word 0) reads 0x0400_0000, with only the FIFO-empty flag set, and `conv_req` is low.
- R2: Word 1 holds slot k's channel in bits 3k+2:3k and the last-slot index in bits 26:24. Word 2 holds the settle count N in bits 7:0 and the timebase select in bits 9:8. Both words read back as written. Read data is valid on the cycle after `reg_rd`.
- R3: A start runs one conversion per slot, from slot 0 through the last index, in that order. `conv_chan` carries the slot's channel, and it is stable while the request is pending. The engine then goes idle.
- R4: Each result is pushed in conversion order. A pop (a read of word 3) returns the channel in bits 14:12 and the code in bits 11:0, with zeros above. The status count (bits 25:21) equals the number of stored results.
- R5: Between conversions the engine waits N+1 timebase ticks. With timebase select 0 the next request rises N+1 cycles after the done cycle. Select s ticks once every 4^s cycles, so the gap lies between 4^s*N+1 and 4^s*(N+1) cycles.
- R6: Busy (status bit 28) reads 1 on a status read issued directly after the start write, and it stays 1 until the engine is idle. Bits 29 and 30 read 0.
- R7: A start strobe (bit 2) is accepted only when the same write also sets enable (bit 0). Otherwise no conversion is requested and busy stays 0.
- R8: With continuous mode (bit 1) set, the engine wraps from the last slot back to slot 0 and keeps converting until stopped.
- R9: A stop strobe (bit 14) during a conversion keeps the request up until done, stores that result, and then goes idle with no further request. A stop during the settle wait goes idle at once.
- R10: The FIFO holds 32 results. When it is full, status bit 27 is set, the count field wraps to 0, and new results are dropped so that the oldest entries survive.
- R11: A pop of an empty FIFO returns 0 and leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of word 3 pops the FIFO) |
| reg_addr | input | 2 | Word select: 0 control/status, 1 channel list, 2 delay, 3 FIFO pop |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| reg_rvalid | output | 1 | Read data valid |
| conv_req | output | 1 | Conversion request, held until done |
| conv_chan | output | 3 | Channel to convert |
| conv_done | input | 1 | One-cycle conversion complete pulse |
| conv_code | input | 12 | Conversion result, valid with `conv_done` |

## Verification
The channel sequencer is exercised with four list patterns:
- a three-slot list of unrelated channels;
- a one-slot list with zero delay;
- a full eight-slot list in descending order;
- a four-slot list with a repeated channel and a long delay.

Together these separate slot ordering from channel value, catch an off-by-one in the last-index handling, and show whether the delay counts N or N+1 cycles. Each result code is derived from a running conversion number, so a dropped, duplicated or reordered FIFO entry shows up as a code mismatch, not only as a tag mismatch. Continuous mode, stops placed both inside a conversion and inside a wait, and a run that overfills the FIFO then cover wrap-around, graceful stop and drop-on-full.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CODE_W = 12;
  localparam int CHAN_W = 3;
  localparam int RES_W  = CHAN_W + CODE_W;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_LIST = 2'd1;
  localparam logic [ADDR_W-1:0] A_DLY  = 2'd2;
  localparam logic [ADDR_W-1:0] A_POP  = 2'd3;

  // control / status word bit positions (software decodes these)
  localparam int B_EN        = 0;
  localparam int B_CONT      = 1;
  localparam int B_START     = 2;
  localparam int B_STOP      = 14;
  localparam int B_CNT_LSB   = 21;
  localparam int CNT_FIELD_W = 5;
  localparam int B_EMPTY     = 26;
  localparam int B_FULL      = 27;
  localparam int B_SBUSY     = 28;
  localparam int B_ABUSY     = 29;
  localparam int B_DBUSY     = 30;

  // list and delay word fields
  localparam int B_LAST_LSB = 24;
  localparam int B_TB_LSB   = 8;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ARM  = 2'd1,
    S_REQ  = 2'd2,
    S_WAIT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [W-1:0]             wdata,
  input  logic                     pop,
  output logic [W-1:0]             rdata,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     empty,
  output logic                     full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;   // drop on full, keep oldest
  assign do_pop  = pop && !empty;

  // storage: write port only, no reset, so it maps to block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  // registered read port; an empty pop yields zero
  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (pop) rdata <= do_pop ? mem[rp] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  // R10: a push into a full FIFO must not change the fill level
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == $past(count)));

  // R11: popping an empty FIFO returns zero and leaves it empty
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (empty && rdata == '0));
endmodule

// File: rtl/adc_seq_delay.sv
module adc_seq_delay #(
  parameter int CNT_W    = 8,
  parameter int SEL_W    = 2,
  parameter int TB_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] n,
  input  logic [SEL_W-1:0] sel,
  output logic             expired
);
  localparam int PRE_W = TB_SHIFT * ((1 << SEL_W) - 1);

  logic [PRE_W-1:0] pre, mask;
  logic [CNT_W-1:0] cnt;
  logic             active, tick;

  always_comb begin
    mask = '0;
    for (int b = 0; b < PRE_W; b++)
      if (b < int'(sel) * TB_SHIFT) mask[b] = 1'b1;
  end

  assign tick    = ((pre & mask) == '0);
  assign expired = active && tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) pre <= '0;
    else     pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= n;
    end else if (active && tick) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  // R5: the wait ends exactly once; expiry retires the counter
  p_single_expiry_r5: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> !active);

  // R5: the count only moves on timebase ticks
  p_tick_only_r5: assert property (@(posedge clk) disable iff (rst)
    (active && !tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    cont,
  input  logic                    start,
  input  logic                    stop,
  input  logic [SLOTS*CHAN_W-1:0] chan_list,
  input  logic [SLOT_W-1:0]       last_idx,
  input  logic                    conv_done,
  input  logic                    dly_expired,
  output logic                    conv_req,
  output logic [CHAN_W-1:0]       conv_chan,
  output logic                    busy,
  output logic                    dly_load,
  output logic                    accept
);
  seq_state_e        state;
  logic [SLOT_W-1:0] slot;
  logic              stop_pend;
  logic [CHAN_W-1:0] entry;
  logic              at_last, finish;

  assign entry    = chan_list[int'(slot)*CHAN_W +: CHAN_W];
  assign at_last  = (slot == last_idx);
  assign finish   = stop || stop_pend || (at_last && !cont);
  assign accept   = (state == S_REQ) && conv_done && en;
  assign dly_load = accept && !finish;
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      slot      <= '0;
      stop_pend <= 1'b0;
      conv_req  <= 1'b0;
      conv_chan <= '0;
    end else if (!en && !start) begin
      state     <= S_IDLE;
      conv_req  <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state     <= S_ARM;
          slot      <= '0;
          stop_pend <= 1'b0;
        end
        S_ARM: if (stop) begin
          state <= S_IDLE;
        end else begin
          state     <= S_REQ;
          conv_req  <= 1'b1;
          conv_chan <= entry;
        end
        S_REQ: if (conv_done) begin
          conv_req <= 1'b0;
          if (finish) begin
            state     <= S_IDLE;
            stop_pend <= 1'b0;
          end else begin
            state <= S_WAIT;
            slot  <= at_last ? '0 : slot + 1'b1;
          end
        end else if (stop) begin
          stop_pend <= 1'b1;
        end
        S_WAIT: if (stop) begin
          state <= S_IDLE;
        end else if (dly_expired) begin
          state     <= S_REQ;
          conv_req  <= 1'b1;
          conv_chan <= entry;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: an accepted start shows busy on the very next cycle
  p_busy_after_start_r6: assert property (@(posedge clk) disable iff (rst)
    (start && state == S_IDLE) |=> busy);

  // R9: a pending request is never withdrawn before done while enabled
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_done && en) |=> conv_req);

  // R3: the channel presented to the converter holds while requested
  p_chan_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_done && en) |=> $stable(conv_chan));

  // R7: no request leaves the engine while it is idle
  p_idle_no_req_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !conv_req);
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int FIFO_DEPTH = 32,
  parameter int DLY_W      = 8,
  parameter int TB_SEL_W   = 2,
  parameter int TB_SHIFT   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic              conv_req,
  output logic [2:0]        conv_chan,
  input  logic              conv_done,
  input  logic [11:0]       conv_code
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int LIST_W = SLOTS * CHAN_W;
  localparam int FCNT_W = $clog2(FIFO_DEPTH) + 1;

  logic              en_q, cont_q;
  logic [LIST_W-1:0] list_q;
  logic [SLOT_W-1:0] last_q;
  logic [DLY_W-1:0]  dly_n_q;
  logic [TB_SEL_W-1:0] dly_sel_q;

  logic wr_ctrl, start, stop;
  logic busy, dly_load, dly_expired, accept;
  logic [RES_W-1:0]  fifo_rdata;
  logic [FCNT_W-1:0] fifo_count;
  logic fifo_empty, fifo_full, pop;
  logic [DATA_W-1:0] status_w, list_w, dly_w, rword_q;
  logic pop_sel_q;
  logic unused_bits;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign start   = wr_ctrl && reg_wdata[B_START] && reg_wdata[B_EN];
  assign stop    = wr_ctrl && reg_wdata[B_STOP];
  assign pop     = reg_rd && (reg_addr == A_POP);

  assign unused_bits = ^{reg_wdata[DATA_W-1:B_LAST_LSB+SLOT_W],
                         fifo_count[FCNT_W-1:CNT_FIELD_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      cont_q    <= 1'b0;
      list_q    <= '0;
      last_q    <= '0;
      dly_n_q   <= '0;
      dly_sel_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL: begin
          en_q   <= reg_wdata[B_EN];
          cont_q <= reg_wdata[B_CONT];
        end
        A_LIST: begin
          list_q <= reg_wdata[LIST_W-1:0];
          last_q <= reg_wdata[B_LAST_LSB +: SLOT_W];
        end
        A_DLY: begin
          dly_n_q   <= reg_wdata[DLY_W-1:0];
          dly_sel_q <= reg_wdata[B_TB_LSB +: TB_SEL_W];
        end
        default: ;
      endcase
    end
  end

  adc_seq_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .en         (en_q),
    .cont       (cont_q),
    .start      (start),
    .stop       (stop),
    .chan_list  (list_q),
    .last_idx   (last_q),
    .conv_done  (conv_done),
    .dly_expired(dly_expired),
    .conv_req   (conv_req),
    .conv_chan  (conv_chan),
    .busy       (busy),
    .dly_load   (dly_load),
    .accept     (accept)
  );

  adc_seq_delay #(.CNT_W(DLY_W), .SEL_W(TB_SEL_W), .TB_SHIFT(TB_SHIFT)) u_delay (
    .clk    (clk),
    .rst    (rst),
    .load   (dly_load),
    .n      (dly_n_q),
    .sel    (dly_sel_q),
    .expired(dly_expired)
  );

  adc_seq_fifo #(.DEPTH(FIFO_DEPTH), .W(RES_W)) u_fifo (
    .clk  (clk),
    .rst  (rst),
    .push (accept),
    .wdata({conv_chan, conv_code}),
    .pop  (pop),
    .rdata(fifo_rdata),
    .count(fifo_count),
    .empty(fifo_empty),
    .full (fifo_full)
  );

  always_comb begin
    status_w = '0;
    status_w[B_EN]    = en_q;
    status_w[B_CONT]  = cont_q;
    status_w[B_CNT_LSB +: CNT_FIELD_W] = fifo_count[CNT_FIELD_W-1:0];
    status_w[B_EMPTY] = fifo_empty;
    status_w[B_FULL]  = fifo_full;
    status_w[B_SBUSY] = busy;
    status_w[B_ABUSY] = 1'b0;
    status_w[B_DBUSY] = 1'b0;

    list_w = '0;
    list_w[LIST_W-1:0] = list_q;
    list_w[B_LAST_LSB +: SLOT_W] = last_q;

    dly_w = '0;
    dly_w[DLY_W-1:0] = dly_n_q;
    dly_w[B_TB_LSB +: TB_SEL_W] = dly_sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      pop_sel_q  <= 1'b0;
      rword_q    <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      pop_sel_q  <= pop;
      if (reg_rd) begin
        case (reg_addr)
          A_CTRL:  rword_q <= status_w;
          A_LIST:  rword_q <= list_w;
          A_DLY:   rword_q <= dly_w;
          default: rword_q <= '0;
        endcase
      end
    end
  end

  // the FIFO read port is itself a register; select it after the flop
  assign reg_rdata = pop_sel_q ? DATA_W'(fifo_rdata) : rword_q;
endmodule

// File: tb/adc_seq_engine_test.sv
module adc_seq_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        conv_req;
  logic [2:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [11:0] conv_code = 12'd0;

  always #10 clk = ~clk;

  adc_seq_engine uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .conv_req(conv_req), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_code(conv_code)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // converter model: answers a request after LAT cycles; the code is
  // (conversion number * 37 + channel) mod 4096
  localparam int LAT = 2;
  int nreq = 0, nconv = 0, gap = 0, last_gap = 0, lat = 0;
  logic req_prev = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (conv_req && !req_prev) begin
        nreq++;
        last_gap = gap;
      end
      req_prev = conv_req;
      if (!conv_req) gap++;
      if (conv_done) conv_done = 1'b0;
      else if (conv_req) begin
        if (lat == LAT) begin
          conv_done = 1'b1;
          conv_code = 12'((nconv * 37 + int'(conv_chan)) % 4096);
          nconv++;
          lat = 0;
          gap = 0;
        end else lat++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd0, s);
      if (!s[28]) break;
    end
  endtask

  task automatic drain();
    logic [31:0] s, d;
    for (int i = 0; i < 40; i++) begin
      rd(2'd0, s);
      if (s[26]) break;
      rd(2'd3, d);
    end
  endtask

  // vector: {channel list[23:0], last index[2:0], settle count[7:0]}
  localparam logic [34:0] VEC [4] = '{
    {24'h0001DD, 3'd2, 8'd3},
    {24'h000006, 3'd0, 8'd0},
    {24'h053977, 3'd7, 8'd1},
    {24'h000852, 3'd3, 8'd10}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, d;
    int b_req, b_conv, b2, ent;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(conv_req == 1'b0, "R1 conv_req", conv_req, 0);
    rd(2'd0, s);
    check(s == 32'h0400_0000, "R1 status", s, 32'h0400_0000);

    // R11 empty pop
    rd(2'd3, d);
    check(d == 0, "R11 empty pop data", d, 0);
    rd(2'd0, s);
    check(s[25:21] == 0 && s[26], "R11 count after empty pop", s, 32'h0400_0000);

    // R2 readback
    wr(2'd1, 32'h0305_3977);
    rd(2'd1, d);
    check(d == 32'h0305_3977, "R2 list readback", d, 32'h0305_3977);
    wr(2'd2, 32'h0000_02AB);
    rd(2'd2, d);
    check(d == 32'h0000_02AB, "R2 delay readback", d, 32'h0000_02AB);

    // R7 start without enable is ignored
    wr(2'd1, 32'h0000_0006);
    wr(2'd2, 32'h0000_0000);
    b_req = nreq;
    wr(2'd0, 32'h0000_0004);
    repeat (20) @(negedge clk);
    check(nreq == b_req, "R7 no request", nreq - b_req, 0);
    rd(2'd0, s);
    check(s[28] == 1'b0, "R7 busy stays 0", s[28], 0);

    // R6 busy visible right after start
    wr(2'd0, 32'h0000_0005);
    rd(2'd0, s);
    check(s[28] == 1'b1, "R6 busy after start", s[28], 1);
    check(s[30:29] == 2'b00, "R6 other busy bits", s[30:29], 0);
    wait_idle();
    drain();

    // table of single-shot passes: R3 R4 R5
    for (int v = 0; v < 4; v++) begin
      logic [23:0] list;
      logic [2:0]  last;
      logic [7:0]  n;
      list = VEC[v][34:11];
      last = VEC[v][10:8];
      n    = VEC[v][7:0];
      wr(2'd1, {5'b0, last, list});
      wr(2'd2, {24'b0, n});
      b_req  = nreq;
      b_conv = nconv;
      wr(2'd0, 32'h0000_0005);
      wait_idle();
      check(nreq - b_req == int'(last) + 1, "R3 conversions per pass", nreq - b_req, int'(last) + 1);
      if (last != 0)
        check(last_gap == int'(n) + 1, "R5 settle gap", last_gap, int'(n) + 1);
      rd(2'd0, s);
      check(int'(s[25:21]) == int'(last) + 1, "R4 fifo count", s[25:21], int'(last) + 1);
      for (int k = 0; k <= int'(last); k++) begin
        logic [2:0] ech;
        ech = list[3*k +: 3];
        rd(2'd3, d);
        check(d[14:12] == ech, "R3 channel order", d[14:12], ech);
        check(int'(d[11:0]) == ((b_conv + k) * 37 + int'(ech)) % 4096 && d[31:15] == 0,
              "R4 result word", d, ((b_conv + k) * 37 + int'(ech)) % 4096);
      end
    end

    // R5 timebase select 1, N=2
    wr(2'd1, {5'b0, 3'd1, 24'h000021});
    wr(2'd2, 32'h0000_0102);
    wr(2'd0, 32'h0000_0005);
    wait_idle();
    check(last_gap >= 9 && last_gap <= 12, "R5 timebase gap", last_gap, 12);
    drain();

    // R9 stop during settle wait
    wr(2'd1, {5'b0, 3'd1, 24'h00000C});
    wr(2'd2, 32'h0000_00C8);
    b_req  = nreq;
    b_conv = nconv;
    wr(2'd0, 32'h0000_0005);
    for (int i = 0; i < 1000 && nconv == b_conv; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    wr(2'd0, 32'h0000_4001);
    repeat (300) @(negedge clk);
    check(nreq - b_req == 1, "R9 stop in wait", nreq - b_req, 1);
    rd(2'd0, s);
    check(s[28] == 1'b0, "R9 idle after stop in wait", s[28], 0);
    drain();

    // R8 continuous wrap, R9 stop during a conversion
    wr(2'd1, {5'b0, 3'd1, 24'h000021});
    wr(2'd2, 32'h0000_0002);
    b_req  = nreq;
    b_conv = nconv;
    wr(2'd0, 32'h0000_0007);
    for (int i = 0; i < 2000 && nreq - b_req < 5; i++) @(negedge clk);
    @(posedge conv_req);
    b2 = nconv;
    wr(2'd0, 32'h0000_4003);
    wait_idle();
    check(nconv == b2 + 1, "R9 in-flight result completes", nconv - b2, 1);
    check(nreq - b_req == nconv - b_conv, "R9 no request after stop", nreq - b_req, nconv - b_conv);
    rd(2'd0, s);
    ent = nconv - b_conv;
    check(int'(s[25:21]) == ent, "R9 in-flight result stored", s[25:21], ent);
    check(ent >= 6, "R8 continuous kept running", ent, 6);
    for (int k = 0; k < ent; k++) begin
      logic [2:0] ech;
      ech = (k % 2 == 0) ? 3'd1 : 3'd4;
      rd(2'd3, d);
      check(d[14:12] == ech && int'(d[11:0]) == ((b_conv + k) * 37 + int'(ech)) % 4096,
            "R8 wrap order", d, ((b_conv + k) * 37 + int'(ech)) % 4096 + (int'(ech) << 12));
    end

    // R10 full FIFO drops new results
    wr(2'd1, 32'h0000_0003);
    wr(2'd2, 32'h0000_0000);
    b_conv = nconv;
    wr(2'd0, 32'h0000_0007);
    for (int i = 0; i < 5000 && nconv - b_conv < 40; i++) @(negedge clk);
    wr(2'd0, 32'h0000_4001);
    wait_idle();
    rd(2'd0, s);
    check(s[27] && !s[26] && s[25:21] == 0, "R10 full flags", s[27:21], 7'h40);
    rd(2'd3, d);
    check(d == 32'((3 << 12) | ((b_conv * 37 + 3) % 4096)), "R10 oldest kept",
          d, (3 << 12) | ((b_conv * 37 + 3) % 4096));
    for (int k = 1; k < 32; k++) rd(2'd3, d);
    check(d == 32'((3 << 12) | (((b_conv + 31) * 37 + 3) % 4096)), "R10 last stored entry",
          d, (3 << 12) | (((b_conv + 31) * 37 + 3) % 4096));
    rd(2'd0, s);
    check(s[26] && s[25:21] == 0, "R10 empty after 32 pops", s[26:21], 6'h20);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule